// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 18-bit buses, A and B, and moves data in both directions. Each direction has its own storage register and three controls: a storage-mode select, a capture strobe and an output enable. When the mode select is high, the storage is transparent and the far bus follows the near bus combinationally. When the mode select is low, the storage holds its content and loads new data only on a rising edge of the capture strobe. The A-to-B enable is active high. The B-to-A enable is active low.

The block runs on a system clock. The capture strobes and mode selects are sampled on that clock, so a strobe edge is detected by comparing its present level with the level seen at the previous clock. Each bus is split into an input word, a per-bit "driven" mask, an output word and an output enable. A level above the block ties these to the physical tri-state wires. Any input bit whose mask bit is low is replaced by the last value seen while that bit was driven. This stands in for bus-hold. While reset is asserted, both output enables are forced off. Reset also clears the storage and the hold values.

Top module: `xcvr_reg18`

## Requirements
- R1: While `ab_le` is high, `b_o` equals the effective A input in the same cycle, bit for bit and not inverted, over all 18 bits.
- R2: While `ab_le` is low and no rising `ab_cp` edge is seen, `b_o` keeps the stored value even when `a_i` changes, and a falling `ab_cp` edge has no effect.
- R3: With `ab_le` low, a clock edge that samples `ab_cp` high after sampling it low at the previous edge loads the effective A input into the A-to-B storage. The new value shows on `b_o` right after that edge.
- R4: Out of reset, `b_oe_o` is high exactly when `ab_oe` is high (active-high enable).
- R5: The B-to-A path uses `ba_le` and `ba_cp` in the same way as R1 to R3, driving `a_o` from the effective B input. Its storage is separate, so B-to-A activity leaves the A-to-B stored value unchanged.
- R6: Out of reset, `a_oe_o` is high exactly when `ba_oe_n` is low (active-low enable).
- R7: While `rst_n` is low, both `a_oe_o` and `b_oe_o` are low whatever the enables are. After reset, both stored values and both hold values read as zero.
- R8: A bit whose `*_drv_i` bit is low is taken as the value that bit had at the last clock edge where it was driven. Bits that are driven pass through as they are.
- R9: When the mode select falls, the storage keeps the value that was passing through at the last edge with the mode select high. A strobe edge sampled at the same edge as the fall loads the current input.
- R10: Both output enables active together is a bus conflict. An assertion flags it, and legal use never shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Value seen on bus A |
| a_drv_i | input | 18 | Per-bit flag: bus A bit is being driven |
| a_o | output | 18 | Value to drive onto bus A |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_i | input | 18 | Value seen on bus B |
| b_drv_i | input | 18 | Per-bit flag: bus B bit is being driven |
| b_o | output | 18 | Value to drive onto bus B |
| b_oe_o | output | 1 | Drive enable for bus B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B transparent select |
| ab_cp | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A transparent select |
| ba_cp | input | 1 | B-to-A capture strobe |

## Verification
Transparent data and both output enables are combinational, so they are due in the same cycle the inputs change. Captured data and hold values are due one clock edge after the sampled strobe or drive pattern, with no further delay. The bench changes every input on the falling clock edge. It then samples a quarter period after the following rising edge, so each check sees exactly one register update. It checks only the cycle in which that result is due.

// File: rtl/xcvr_reg18.sv
module xcvr_reg18 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] a_drv_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] b_drv_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_oe,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_cp
);

  logic [W-1:0] a_hold, b_hold, a_eff, b_eff, ab_q, ba_q;
  logic         ab_cp_q, ba_cp_q;

  // bus-hold: undriven bits fall back to their last driven value
  assign a_eff = (a_drv_i & a_i) | (~a_drv_i & a_hold);
  assign b_eff = (b_drv_i & b_i) | (~b_drv_i & b_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hold  <= '0;
      b_hold  <= '0;
      ab_q    <= '0;
      ba_q    <= '0;
      ab_cp_q <= 1'b1;
      ba_cp_q <= 1'b1;
    end else begin
      a_hold  <= a_eff;
      b_hold  <= b_eff;
      ab_cp_q <= ab_cp;
      ba_cp_q <= ba_cp;
      if (ab_le || (ab_cp && !ab_cp_q)) ab_q <= a_eff;
      if (ba_le || (ba_cp && !ba_cp_q)) ba_q <= b_eff;
    end
  end

  assign b_o    = ab_le ? a_eff : ab_q;
  assign a_o    = ba_le ? b_eff : ba_q;
  assign b_oe_o = rst_n & ab_oe;
  assign a_oe_o = rst_n & ~ba_oe_n;

  assert_ab_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && (&a_drv_i)) |-> (b_o == a_i));

  assert_ab_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(ab_cp) && !ab_le && (&a_drv_i)) |=> (ab_le || (b_o == $past(a_i))));

  assert_ba_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le && (&b_drv_i)) |-> (a_o == b_i));

  assert_reset_off_R7: assert property (@(posedge clk)
    !rst_n |-> (!a_oe_o && !b_oe_o));

  assert_hold_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ab_le && $past(a_drv_i[0]) && !a_drv_i[0]) |-> (b_o[0] == $past(a_i[0])));

  assert_no_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe_o && b_oe_o));

endmodule

// File: tb/xcvr_reg18_tb.sv
module xcvr_reg18_tb;
  localparam int P = 10;
  localparam int W = 18;

  typedef struct packed {
    logic         le;
    logic         cp;
    logic [W-1:0] a;
    logic [W-1:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 18'h12345, 18'h12345},
    '{1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF},
    '{1'b0, 1'b0, 18'h00AAA, 18'h3FFFF},
    '{1'b0, 1'b1, 18'h15555, 18'h15555},
    '{1'b0, 1'b1, 18'h2AAAA, 18'h15555},
    '{1'b0, 1'b0, 18'h00001, 18'h15555},
    '{1'b0, 1'b1, 18'h00001, 18'h00001},
    '{1'b1, 1'b1, 18'h0F0F0, 18'h0F0F0},
    '{1'b0, 1'b0, 18'h33333, 18'h0F0F0},
    '{1'b0, 1'b1, 18'h33333, 18'h33333},
    '{1'b1, 1'b0, 18'h0ABCD, 18'h0ABCD},
    '{1'b0, 1'b1, 18'h0ABCD, 18'h0ABCD}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_i = '0, a_drv_i = '1, b_i = '0, b_drv_i = '1;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o;
  logic ab_oe = 1'b1, ab_le = 1'b0, ab_cp = 1'b0;
  logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_cp = 1'b0;
  int checks = 0, fails = 0, conflicts = 0;

  always #(P/2) clk = ~clk;

  xcvr_reg18 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_i(a_i), .a_drv_i(a_drv_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_drv_i(b_drv_i), .b_o(b_o), .b_oe_o(b_oe_o),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_cp(ab_cp),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_cp(ba_cp)
  );

  always @(negedge clk) if (rst_n && a_oe_o && b_oe_o) conflicts++;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(P/4);
  endtask

  initial begin
    #(P * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R7: enables forced off during reset
    #(P + 2);
    chk("R7 oe during reset", {16'd0, a_oe_o, b_oe_o}, '0);
    @(negedge clk);
    ba_oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 storage cleared", b_o, '0);
    chk("R4 b_oe_o with ab_oe high", {17'd0, b_oe_o}, 18'd1);

    // R1 R2 R3 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ab_le = VEC[i].le;
      ab_cp = VEC[i].cp;
      a_i   = VEC[i].a;
      tick();
      chk($sformatf("R1/R2/R3/R9 vector %0d", i), b_o, VEC[i].exp);
    end

    // R4 and R6: enable polarities
    @(negedge clk);
    ab_oe = 1'b0;
    #1;
    chk("R4 b_oe_o with ab_oe low", {17'd0, b_oe_o}, '0);
    ba_oe_n = 1'b0;
    #1;
    chk("R6 a_oe_o with ba_oe_n low", {17'd0, a_oe_o}, 18'd1);

    // R5: B-to-A transparent, then capture
    ba_le = 1'b1;
    b_i = 18'h1E1E1;
    tick();
    chk("R5 b-to-a transparent", a_o, 18'h1E1E1);
    @(negedge clk);
    ba_le = 1'b0;
    b_i = 18'h07777;
    tick();
    chk("R5 b-to-a held after le fall", a_o, 18'h1E1E1);
    @(negedge clk);
    ba_cp = 1'b1;
    tick();
    chk("R5 b-to-a capture", a_o, 18'h07777);
    @(negedge clk);
    ba_oe_n = 1'b1;
    #1;
    chk("R6 a_oe_o with ba_oe_n high", {17'd0, a_oe_o}, '0);
    ab_oe = 1'b1;
    a_i = 18'h11111;
    tick();
    chk("R5 a-to-b storage untouched", b_o, 18'h0ABCD);

    // R8: bus-hold on undriven bits
    @(negedge clk);
    ab_le = 1'b1;
    a_i = 18'h2D2D2;
    tick();
    chk("R8 driven baseline", b_o, 18'h2D2D2);
    @(negedge clk);
    a_drv_i = 18'h001FF;
    a_i = '0;
    #1;
    chk("R8 partial float", b_o, 18'h2D200);
    tick();
    chk("R8 partial float after edge", b_o, 18'h2D200);
    @(negedge clk);
    a_drv_i = '0;
    a_i = 18'h3FFFF;
    tick();
    chk("R8 full float", b_o, 18'h2D200);

    chk("R10 no enable conflict seen", conflicts[W-1:0], '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule